// File: doc/BRIEF.md
# USB Data Packet Receive Controller

This block sits behind a USB bit-recovery front end that has already removed NRZI coding and bit stuffing and hands over one byte at a time with a valid strobe, plus an end-of-packet indication. The controller checks that a packet opens with the sync byte and carries a data-type PID. It passes every byte of the data field into an external receive FIFO and runs a CRC-16 over the same bytes. At end of packet it accepts the packet or raises a one-cycle error pulse.

Packets that fail the header checks are discarded up to their end-of-packet mark. The two CRC bytes at the tail of the data field reach the FIFO like any other data byte, because the controller cannot tell which bytes are the CRC until end of packet arrives. The error pulse tells the reader to discard what was written.

Top module: `usb_rx_pkt_ctrl`

## Requirements
- R1: After reset `fifo_we` and `rx_error` are low, and the controller waits for the first byte of a packet.
- R2: If the first byte of a packet is not 8'h80, no byte of that packet is written and no error is raised. The controller ignores bytes until end of packet.
- R3: The second byte is the PID. It is a data PID only when its low nibble is 4'b0011 or 4'b1011 and its high nibble is the bitwise complement of its low nibble. Any other PID gives one error pulse, and the rest of the packet is ignored without writes.
- R4: After a data PID, each data byte, including the two trailing CRC bytes, appears on `fifo_wdata` with `fifo_we` high for exactly one cycle. This happens one cycle after its `rx_valid` strobe, in arrival order.
- R5: The CRC register starts at 16'hFFFF and takes each byte least significant bit first, using polynomial x^16+x^15+x^2+1. At end of packet in the data field, a remainder other than 16'h800D gives an error pulse one cycle after `rx_eop`. A remainder equal to 16'h800D gives no pulse.
- R6: A data byte that arrives while `fifo_full` is high is not written and gives an error pulse one cycle later. The byte still enters the CRC and the packet continues.
- R7: Every end-of-packet mark returns the controller to waiting for a sync byte, so the next byte is checked as sync.
- R8: When `rx_valid` and `rx_eop` are high in the same cycle, the end of packet is processed and the byte is discarded: it is neither written nor added to the CRC.
- R9: End of packet after the sync byte but before a PID gives an error pulse.
- R10: `rx_error` is a single-cycle pulse. It follows only a cycle with `rx_valid` or `rx_eop` high, and it is never high in the same cycle as `fifo_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte from the front end |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| rx_eop | input | 1 | End of packet seen this cycle |
| fifo_full | input | 1 | Receive FIFO cannot take a byte |
| fifo_wdata | output | 8 | Byte written to the receive FIFO |
| fifo_we | output | 1 | FIFO write strobe |
| rx_error | output | 1 | One-cycle packet error pulse |

## Verification
A wrong state register shows up one cycle after the next input event. A packet stuck in the ignore state loses its writes at the first data byte. A controller that does not return to idle writes the sync or PID of the next packet into the FIFO. A wrong CRC register stays hidden until end of packet and then shows as a missing or spurious error pulse one cycle after `rx_eop`. For that reason the bench compares the error count of every packet as well as every written byte, including packets with bad CRC, a full FIFO and an end-of-packet mark paired with a byte.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;

    localparam logic [BYTE_W-1:0] SYNC_PATTERN = 8'h80;
    localparam logic [CRC_W-1:0]  CRC_POLY     = 16'h8005;
    localparam logic [CRC_W-1:0]  CRC_SEED     = 16'hFFFF;
    localparam logic [CRC_W-1:0]  CRC_RESIDUE  = 16'h800D;

    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PID,
        ST_DATA,
        ST_DROP
    } rx_state_e;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] data;
        logic              err;
    } rx_out_s;

    // High nibble must mirror low nibble inverted; low nibble picks DATA0/DATA1
    function automatic logic pid_is_data(input logic [BYTE_W-1:0] pid);
        logic check_ok;
        logic type_ok;
        check_ok = (pid[7:4] == ~pid[3:0]);
        type_ok  = (pid[3:0] == PID_DATA0) || (pid[3:0] == PID_DATA1);
        return check_ok && type_ok;
    endfunction

endpackage

// File: rtl/usb_rx_hdr_chk.sv
module usb_rx_hdr_chk
    import usb_rx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SYNC_VAL = SYNC_PATTERN
) (
    input  logic [BYTE_W-1:0] hdr_byte,
    output logic              sync_ok,
    output logic              pid_ok
);

    always_comb begin
        sync_ok = (hdr_byte == SYNC_VAL);
        pid_ok  = pid_is_data(hdr_byte);
    end

endmodule

// File: rtl/usb_rx_crc16.sv
module usb_rx_crc16
    import usb_rx_pkg::*;
#(
    parameter int              W    = CRC_W,
    parameter int              DW   = BYTE_W,
    parameter logic [W-1:0]    POLY = CRC_POLY,
    parameter logic [W-1:0]    SEED = CRC_SEED
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          update,
    input  logic [DW-1:0] din,
    output logic [W-1:0]  crc
);

    logic [W-1:0] crc_q;
    logic [W-1:0] stage [0:DW];

    assign stage[0] = crc_q;

    // One shift step per input bit, least significant bit first
    generate
        for (genvar i = 0; i < DW; i++) begin : g_bit
            logic fb;
            assign fb           = stage[i][W-1] ^ din[i];
            assign stage[i+1]   = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= SEED;
        end else if (update) begin
            crc_q <= stage[DW];
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/usb_rx_pkt_ctrl.sv
module usb_rx_pkt_ctrl
    import usb_rx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SYNC_VAL  = SYNC_PATTERN,
    parameter logic [CRC_W-1:0]  CRC_GOOD  = CRC_RESIDUE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_eop,
    input  logic              fifo_full,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              fifo_we,
    output logic              rx_error
);

    rx_state_e        state_q, state_n;
    rx_out_s          out_q, out_n;
    logic             sync_ok, pid_ok;
    logic             crc_clr, crc_upd;
    logic [CRC_W-1:0] crc_val;

    usb_rx_hdr_chk #(
        .SYNC_VAL (SYNC_VAL)
    ) u_hdr (
        .hdr_byte (rx_byte),
        .sync_ok  (sync_ok),
        .pid_ok   (pid_ok)
    );

    usb_rx_crc16 u_crc (
        .clk    (clk),
        .rst    (rst),
        .clear  (crc_clr),
        .update (crc_upd),
        .din    (rx_byte),
        .crc    (crc_val)
    );

    always_comb begin
        state_n      = state_q;
        out_n.we     = 1'b0;
        out_n.err    = 1'b0;
        out_n.data   = out_q.data;
        crc_clr      = (state_q != ST_DATA);
        crc_upd      = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (rx_eop) begin
                    state_n = ST_IDLE;
                end else if (rx_valid) begin
                    state_n = sync_ok ? ST_PID : ST_DROP;
                end
            end
            ST_PID: begin
                if (rx_eop) begin
                    out_n.err = 1'b1;
                    state_n   = ST_IDLE;
                end else if (rx_valid) begin
                    if (pid_ok) begin
                        state_n = ST_DATA;
                    end else begin
                        out_n.err = 1'b1;
                        state_n   = ST_DROP;
                    end
                end
            end
            ST_DATA: begin
                if (rx_eop) begin
                    out_n.err = (crc_val != CRC_GOOD);
                    state_n   = ST_IDLE;
                end else if (rx_valid) begin
                    crc_upd = 1'b1;
                    if (fifo_full) begin
                        out_n.err = 1'b1;
                    end else begin
                        out_n.we   = 1'b1;
                        out_n.data = rx_byte;
                    end
                end
            end
            ST_DROP: begin
                if (rx_eop) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            out_q   <= '0;
        end else begin
            state_q <= state_n;
            out_q   <= out_n;
        end
    end

    assign fifo_we    = out_q.we;
    assign fifo_wdata = out_q.data;
    assign rx_error   = out_q.err;

endmodule

// File: rtl/usb_rx_pkt_ctrl_sva.sv
module usb_rx_pkt_ctrl_sva (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       rx_eop,
    input logic       fifo_full,
    input logic [7:0] fifo_wdata,
    input logic       fifo_we,
    input logic       rx_error
);

    assert_we_after_valid_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> $past(rx_valid) && !$past(rx_eop));

    assert_we_data_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> fifo_wdata == $past(rx_byte));

    assert_no_write_full_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> !$past(fifo_full));

    assert_eop_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        rx_eop |=> !fifo_we);

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        rx_error |-> ($past(rx_valid) || $past(rx_eop)));

    assert_err_we_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(rx_error && fifo_we));

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rx_error && !$past(rx_valid && !rx_eop) |=> !rx_error || $past(rx_valid || rx_eop));

endmodule

bind usb_rx_pkt_ctrl usb_rx_pkt_ctrl_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .rx_eop     (rx_eop),
    .fifo_full  (fifo_full),
    .fifo_wdata (fifo_wdata),
    .fifo_we    (fifo_we),
    .rx_error   (rx_error)
);

// File: tb/tb_usb_rx_pkt_ctrl.sv
module tb_usb_rx_pkt_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic       rx_eop = 1'b0;
    logic       fifo_full = 1'b0;
    logic [7:0] fifo_wdata;
    logic       fifo_we;
    logic       rx_error;

    int n_checks = 0;
    int n_errors = 0;
    int err_seen = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    logic [7:0] pkt[$];

    always #4 clk = ~clk;

    usb_rx_pkt_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_eop     (rx_eop),
        .fifo_full  (fifo_full),
        .fifo_wdata (fifo_wdata),
        .fifo_we    (fifo_we),
        .rx_error   (rx_error)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every write, counts error pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_we) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4 unexpected write", int'(fifo_wdata), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(fifo_wdata == e, "R4 write data", int'(fifo_wdata), int'(e));
                end
            end
            if (rx_error) err_seen++;
        end
    end

    // Reflected CRC-16 as sent on the wire; the appended field is its inverse
    function automatic logic [15:0] wire_crc(input logic [7:0] d[$]);
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                logic fb;
                fb = c[0] ^ d[k][i];
                c  = c >> 1;
                if (fb) c = c ^ 16'hA001;
            end
        end
        return ~c;
    endfunction

    task automatic build(input logic [7:0] pid, input int n, input int seed);
        logic [7:0] d[$];
        logic [15:0] c;
        d = {};
        for (int i = 0; i < n; i++) d.push_back(8'((seed * 37 + i * 11 + i * i) & 8'hFF));
        c = wire_crc(d);
        pkt = {};
        pkt.push_back(8'h80);
        pkt.push_back(pid);
        foreach (d[i]) pkt.push_back(d[i]);
        pkt.push_back(c[7:0]);
        pkt.push_back(c[15:8]);
    endtask

    task automatic drive(input logic [7:0] b, input logic v, input logic e, input logic f);
        @(negedge clk);
        rx_byte   = b;
        rx_valid  = v;
        rx_eop    = e;
        fifo_full = f;
    endtask

    // Sends pkt; bytes from index exp_from on are expected in the FIFO
    task automatic send(input int exp_from, input int full_idx, input int gap);
        foreach (pkt[i]) begin
            if (i >= exp_from && i != full_idx) exp_q.push_back(pkt[i]);
            drive(pkt[i], 1'b1, 1'b0, (i == full_idx));
            for (int g = 0; g < gap; g++) drive(8'h00, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_pkt(input int exp_err, input string req);
        drive(8'h00, 1'b0, 1'b1, 1'b0);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        check(err_seen == exp_err, req, err_seen, exp_err);
        check(exp_q.size() == 0, {req, " pending writes"}, exp_q.size(), 0);
        err_seen = 0;
        exp_q = {};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(fifo_we == 1'b0, "R1 we after reset", fifo_we, 0);
        check(rx_error == 1'b0, "R1 err after reset", rx_error, 0);
        rst = 1'b0;
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        check(fifo_we == 1'b0 && rx_error == 1'b0, "R1 idle outputs", fifo_we, 0);

        // R1 R4 R5: good DATA0 packet right after reset
        build(8'hC3, 4, 1); send(2, -1, 0); finish_pkt(0, "R5 good DATA0");
        // R3 R4: DATA1 with gaps between bytes
        build(8'h4B, 7, 5); send(2, -1, 2); finish_pkt(0, "R3 good DATA1 gaps");
        // R5: empty data field
        build(8'hC3, 0, 0); send(2, -1, 0); finish_pkt(0, "R5 empty field");
        // R5: corrupted CRC
        build(8'h4B, 5, 9); pkt[4] = pkt[4] ^ 8'h10; send(2, -1, 0);
        finish_pkt(1, "R5 bad crc");
        // R2: bad sync
        build(8'hC3, 3, 2); pkt[0] = 8'h81; send(99, -1, 0); finish_pkt(0, "R2 bad sync");
        // R3: token PID and a PID with broken complement
        build(8'hE1, 3, 3); send(99, -1, 0); finish_pkt(1, "R3 token pid");
        build(8'h33, 3, 3); send(99, -1, 0); finish_pkt(1, "R3 bad check nibble");
        // R6: byte lost to full FIFO, CRC still good
        build(8'hC3, 4, 4); send(2, 3, 0); finish_pkt(1, "R6 full write");
        // R9: EOP right after sync
        drive(8'h80, 1'b1, 1'b0, 1'b0); finish_pkt(1, "R9 early eop");
        // R8: byte paired with EOP is dropped
        build(8'h4B, 3, 6); send(2, -1, 0);
        drive(8'h55, 1'b1, 1'b1, 1'b0);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        check(err_seen == 0, "R8 eop with byte", err_seen, 0);
        check(exp_q.size() == 0, "R8 pending", exp_q.size(), 0);
        err_seen = 0;
        // R7: bad-sync packet then good packet with no gap after EOP
        build(8'hC3, 2, 7); pkt[0] = 8'h00; send(99, -1, 0);
        drive(8'h00, 1'b0, 1'b1, 1'b0);
        build(8'hC3, 2, 8); send(2, -1, 0); finish_pkt(0, "R7 back to back");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule